// File: doc/BRIEF.md
# Shared-Prescaler Multi-Channel PWM Controller

This block generates a set of pulse-width-modulated outputs that all run from one time base. An 8-bit prescaler divides the input clock down to a local tick. A shared 8-bit counter steps once per tick through 256 positions, so each output period lasts 256 local cycles. Each channel compares that counter with its own duty value and drives its output high from the start of the period up to and including the duty position. As a result a duty of 0 still gives a one-cycle pulse, and a duty of 255 holds the output high for the whole period.

Software programs the block through a small word-addressed register bus. Every channel has its own duty word, and the channel count is a build parameter. One control word holds the shared prescaler, split over two separate nibbles, together with a single run bit for all channels. A separate word holds the interrupt enable, which gates a one-clock pulse raised at every period boundary. New duty and prescaler values are applied only when a period starts, so a period is never cut short or stretched.

Top module: `shared_pwm_ctrl`

## Requirements
- R1: After reset every register reads 0, all PWM outputs are low and the interrupt output is low.
- R2: The register map is as follows. The duty word of channel n is at byte address 4·n, and its bits [7:0] are the duty value. The control word is at 0x50: prescaler bits [3:0] sit in control bits [3:0], prescaler bits [7:4] sit in control bits [14:11], and the run flag is bit 9. The interrupt-enable word is at 0x54, and its bit 0 is the enable. A mapped word reads back the full 32-bit value last written. Unmapped or unaligned addresses (bits [1:0] not zero) read 0, and writes to them change nothing.
- R3: While running, the shared counter advances once every (prescaler + 1) input clocks and wraps from 255 to 0, so one period is 256·(prescaler + 1) input clocks.
- R4: A channel output is high while the counter is at or below its duty value. Duty d therefore gives (d + 1) local cycles high per period: duty 0 gives exactly one, and duty 255 keeps the output high all the time.
- R5: A duty or prescaler value written while running takes effect only when the counter next wraps to 0. The period in progress finishes with the old values.
- R6: While the run flag is clear, the counter and prescaler are held at zero and all outputs are low. One clock after a write sets the run flag, counting starts from counter 0 using the values then in the registers.
- R7: When interrupt-enable bit 0 is set, the interrupt output pulses high for exactly one input clock at each counter wrap, in the first clock of the new period. When that bit is clear, the interrupt output stays low.
- R8: The prescaler and the run flag apply to every channel together. Changing the prescaler scales the high time of all channels by the same factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| pwm_o | output | NUM_CH | Per-channel PWM outputs |
| irq_o | output | 1 | Period-boundary interrupt pulse |

## Verification
Assertions check the following on every cycle:
- The idle hold of the counter and prescaler.
- That the counter only moves on a prescaler tick.
- That the prescaler count stays within its bound.
- That the active prescaler only changes at a wrap.
- That an output only rises when a period starts, and only falls one step past its duty.
- That an interrupt only appears in the first clock of a period.

Other behaviours can only be shown by the bench's scenarios, which compare against a behavioural model on every clock and measure high times over whole periods:
- The exact pulse widths for duty 0, a mid value and 255.
- How a mid-period duty or prescaler write is deferred.
- Prescale scaling across all channels.
- The readback of the split prescaler field.
- That writes to unmapped addresses are ignored.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 8;
    localparam int PS_W      = 8;
    localparam int CTRL_OFS  = 'h50;
    localparam int IEN_OFS   = 'h54;
    localparam int RUN_BIT   = 9;
    localparam int PS_LO_LSB = 0;
    localparam int PS_HI_LSB = 11;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic            run;
    } ctrl_t;

    function automatic logic [PS_W-1:0] ps_join(input logic [3:0] lo, input logic [3:0] hi);
        return {hi, lo};
    endfunction
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 1,
    parameter int ADDR_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output ctrl_t                       ctrl_o,
    output logic                        ien_o,
    output logic [NUM_CH-1:0][CNT_W-1:0] duty_o
);
    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [WIDX_W-1:0] CTRL_IDX = WIDX_W'(CTRL_OFS / 4);
    localparam logic [WIDX_W-1:0] IEN_IDX  = WIDX_W'(IEN_OFS / 4);

    logic [WIDX_W-1:0] widx;
    logic              hit;
    logic              wr_hit;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] ien_q;
    logic [NUM_CH-1:0][DATA_W-1:0] duty_q;

    assign widx   = bus_addr[ADDR_W-1:2];
    assign hit    = bus_sel && (bus_addr[1:0] == 2'b00);
    assign wr_hit = hit && bus_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ien_q  <= '0;
        end else if (wr_hit) begin
            if (widx == CTRL_IDX) ctrl_q <= bus_wdata;
            if (widx == IEN_IDX)  ien_q  <= bus_wdata;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_duty
        always_ff @(posedge clk) begin
            if (rst)                                      duty_q[g] <= '0;
            else if (wr_hit && widx == WIDX_W'(g))        duty_q[g] <= bus_wdata;
        end
        assign duty_o[g] = duty_q[g][CNT_W-1:0];
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            if (widx == CTRL_IDX)     bus_rdata = ctrl_q;
            else if (widx == IEN_IDX) bus_rdata = ien_q;
            else begin
                for (int i = 0; i < NUM_CH; i++)
                    if (widx == WIDX_W'(i)) bus_rdata = duty_q[i];
            end
        end
    end

    assign ctrl_o.ps  = ps_join(ctrl_q[PS_LO_LSB +: 4], ctrl_q[PS_HI_LSB +: 4]);
    assign ctrl_o.run = ctrl_q[RUN_BIT];
    assign ien_o      = ien_q[0];
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PS_W-1:0]  ps_req,
    output logic             live,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             load
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [PS_W-1:0] pre;
    logic [PS_W-1:0] ps_act;
    logic            tick;

    assign tick = (pre == ps_act);
    assign wrap = live && tick && (cnt == TOP);
    assign load = !live || wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            live   <= 1'b0;
            pre    <= '0;
            cnt    <= '0;
            ps_act <= '0;
        end else begin
            live <= run;
            if (!live) begin
                pre <= '0;
                cnt <= '0;
            end else begin
                pre <= tick ? '0 : pre + 1'b1;
                if (tick) cnt <= cnt + 1'b1;
            end
            if (load) ps_act <= ps_req;
        end
    end

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !live |=> (cnt == '0 && pre == '0));
    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (live && !tick) |=> $stable(cnt));
    // R3
    pre_bound_chk: assert property (@(posedge clk) disable iff (rst)
        live |-> (pre <= ps_act));
    // R5
    ps_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (live && !wrap) |=> $stable(ps_act));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             live,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty_req,
    output logic             out
);
    logic [CNT_W-1:0] duty_act;

    always_ff @(posedge clk) begin
        if (rst)       duty_act <= '0;
        else if (load) duty_act <= duty_req;
    end

    assign out = live && (cnt <= duty_act);

    // R5
    rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out) |-> (cnt == '0));
    // R4
    fall_point_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(out) && live) |-> (cnt == CNT_W'($past(duty_act) + 1'b1)));
endmodule

// File: rtl/shared_pwm_ctrl.sv
module shared_pwm_ctrl
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 1,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_o,
    output logic              irq_o
);
    ctrl_t                        ctrl;
    logic                         ien;
    logic [NUM_CH-1:0][CNT_W-1:0] duty;
    logic                         live;
    logic [CNT_W-1:0]             cnt;
    logic                         wrap;
    logic                         load;

    pwm_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctrl_o(ctrl), .ien_o(ien), .duty_o(duty)
    );

    pwm_timebase u_tb (
        .clk(clk), .rst(rst), .run(ctrl.run), .ps_req(ctrl.ps),
        .live(live), .cnt(cnt), .wrap(wrap), .load(load)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel u_ch (
            .clk(clk), .rst(rst), .live(live), .load(load),
            .cnt(cnt), .duty_req(duty[g]), .out(pwm_o[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= ien && wrap;
    end

    // R7
    irq_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (live && cnt == '0));
endmodule

// File: tb/test_shared_pwm_ctrl.sv
module test_shared_pwm_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam int AW  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] pwm_o;
    logic irq_o;

    int checks = 0, errors = 0;
    bit cmp_on = 1'b0;

    shared_pwm_ctrl #(.NUM_CH(NCH), .ADDR_W(AW)) i_shared_pwm_ctrl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_o(pwm_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int m_ctrl, m_ien, m_duty[NCH], m_aduty[NCH];
    int m_aps, m_pre, m_cnt;
    bit m_live, m_irq;

    function automatic int ps_of(int c);
        return (((c >> 11) & 15) << 4) | (c & 15);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 0; m_ien = 0; m_aps = 0; m_pre = 0; m_cnt = 0;
            m_live = 0; m_irq = 0;
            for (int i = 0; i < NCH; i++) begin m_duty[i] = 0; m_aduty[i] = 0; end
        end else begin
            bit wrp;
            wrp = 0;
            if (!m_live) begin
                m_pre = 0; m_cnt = 0; m_aps = ps_of(m_ctrl);
                for (int i = 0; i < NCH; i++) m_aduty[i] = m_duty[i] & 255;
            end else if (m_pre == m_aps) begin
                m_pre = 0;
                if (m_cnt == 255) begin
                    wrp = 1; m_cnt = 0; m_aps = ps_of(m_ctrl);
                    for (int i = 0; i < NCH; i++) m_aduty[i] = m_duty[i] & 255;
                end else m_cnt = m_cnt + 1;
            end else m_pre = m_pre + 1;
            m_irq  = (m_ien & 1) && wrp;
            m_live = (m_ctrl >> 9) & 1;
            if (bus_sel && bus_wr && bus_addr[1:0] == 2'b00) begin
                int idx;
                idx = int'(bus_addr) >> 2;
                if (idx == 20) m_ctrl = bus_wdata;
                else if (idx == 21) m_ien = bus_wdata;
                else if (idx < NCH) m_duty[idx] = bus_wdata;
            end
        end
    end

    always @(posedge clk) begin
        #2;
        if (cmp_on && !rst) begin
            for (int i = 0; i < NCH; i++) begin
                bit e;
                e = m_live && (m_cnt <= m_aduty[i]);
                checks++;
                if (pwm_o[i] !== e) begin
                    errors++;
                    $display("FAIL R4/R5/R6/R8 ch%0d out=%b exp=%b at %0t", i, pwm_o[i], e, $time);
                end
            end
            checks++;
            if (irq_o !== m_irq) begin
                errors++;
                $display("FAIL R7 irq=%b exp=%b at %0t", irq_o, m_irq, $time);
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd_chk(string req, int a, int exp);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = AW'(a);
        #1;
        chk(req, int'(bus_rdata), exp);
        bus_sel = 0;
    endtask

    task automatic count_high(int ch, int n, output int hi, output int irqs);
        hi = 0; irqs = 0;
        repeat (n) begin
            @(posedge clk); #2;
            if (pwm_o[ch]) hi++;
            if (irq_o) irqs++;
        end
    endtask

    function automatic int mk_ctrl(int ps, int run);
        return ((ps >> 4) << 11) | (run << 9) | (ps & 15);
    endfunction

    int hi, irqs;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        rd_chk("R1 ctrl", 'h50, 0);
        rd_chk("R1 ien", 'h54, 0);
        rd_chk("R1 duty0", 'h00, 0);
        chk("R1 outputs", int'(pwm_o), 0);
        chk("R1 irq", int'(irq_o), 0);
        cmp_on = 1;
        // R2 readback, masking, unmapped
        wr('h00, 'hABCD_0000);
        wr('h04, 127); wr('h08, 255);
        rd_chk("R2 duty1", 'h04, 127);
        wr('h00, 'h1234_5600);
        rd_chk("R2 duty0 full word", 'h00, 'h1234_5600);
        wr('h40, 'hFFFF); wr('h05, 'hFF);
        rd_chk("R2 unmapped read", 'h40, 0);
        rd_chk("R2 unaligned write ignored", 'h04, 127);
        rd_chk("R2 unaligned read", 'h05, 0);
        wr('h54, 1);
        rd_chk("R2 ien", 'h54, 1);
        // R6 idle: not running, outputs low
        count_high(2, 20, hi, irqs);
        chk("R6 idle output", hi, 0);
        // R3 R4 ps=0: duty0 byte=0 ->1, duty1=127 ->128, duty2=255 ->256
        wr('h50, mk_ctrl(0, 1));
        rd_chk("R2 ctrl", 'h50, 'h200);
        repeat (300) @(posedge clk);
        count_high(0, 256, hi, irqs); chk("R4 duty 0 one cycle", hi, 1);
        chk("R7 one irq per period", irqs, 1);
        count_high(1, 256, hi, irqs); chk("R4 duty 127", hi, 128);
        count_high(2, 256, hi, irqs); chk("R4 duty 255 constant", hi, 256);
        // R5 mid-period duty change deferred (model compares every cycle)
        repeat (100) @(posedge clk);
        wr('h04, 10);
        repeat (400) @(posedge clk);
        count_high(1, 256, hi, irqs); chk("R5 new duty applied", hi, 11);
        // R8 split prescaler 0x13 -> 20 clocks per local cycle
        wr('h50, mk_ctrl('h13, 1));
        rd_chk("R2 split ps", 'h50, 'h0A03);
        repeat (10500) @(posedge clk);
        count_high(1, 5120, hi, irqs); chk("R8 ch1 scaled", hi, 220);
        chk("R3 irq per long period", irqs, 1);
        count_high(0, 5120, hi, irqs); chk("R8 ch0 scaled", hi, 20);
        // R7 interrupt disabled
        wr('h54, 0);
        count_high(2, 5200, hi, irqs); chk("R7 no irq when off", irqs, 0);
        // R6 stop and restart
        wr('h50, mk_ctrl(2, 0));
        repeat (3) @(posedge clk);
        count_high(2, 50, hi, irqs); chk("R6 stopped", hi, 0);
        wr('h00, 3); wr('h54, 1);
        wr('h50, mk_ctrl(2, 1));
        repeat (800) @(posedge clk);
        count_high(0, 768, hi, irqs); chk("R6 restart duty3 ps2", hi, 12);
        chk("R7 irq restart", irqs, 1);
        cmp_on = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule